// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is the control unit of a small 16-bit accumulator processor built as a multicycle machine. It steps through a fixed set of fourteen states held in a 4-bit register. Its inputs are the opcode field of the latched instruction word and the sign bit of the accumulator. In every cycle it drives the datapath control points: ALU function, memory bus command, program-counter source and base, data-register load, accumulator load, address-register source and load, and whether the accumulator drives the data bus. The datapath, the memory and the indirect-addressing bit are outside the block; every instruction runs in direct mode.

After reset the sequencer clears the program counter, moves it into the address register and steps it by two. From then on it keeps one rule: whenever it enters the fetch state, the address register holds the address of the instruction about to be read and the program counter points two bytes past it. Fetch reads memory into the data register and branches on the opcode. Each execute path restores the rule before it returns. The conditional branch assumes at first that it is not taken, and spends one more cycle only when the accumulator is negative.

The control outputs are a Moore function of the state. The one exception is the ALU function in the two ALU states, which also depends on the low opcode bit of the latched instruction. That bit is stable for the whole instruction.

Top module: `acc_ctrl_seq`

## Requirements
- R1: `seq_state` shows the current state with these codes: reset-A 0, reset-B 1, fetch 2, two-operand ALU 3, single-operand ALU 4, store-A 5, store-B 6, store-C 7, load-A 8, load-B 9, load-C 10, branch-A 11, branch-B 12, jump 13. While `rst_n` is low at a clock edge, the state becomes 0.
- R2: From reset-A (outputs: `pc_sel`=01 clear, all else 0) the state goes to reset-B and then to fetch. Reset-B performs the restore action of R9.
- R3: Fetch drives `mem_op`=01 (read) and `dr_ld`=1, with everything else 0. It branches on `opcode[2:0]`: 000/001 go to 4, 110/111 to 3, 010 to 11, 011 to 13, 100 to 5 and 101 to 8. `opcode[4:3]` has no effect.
- R4: State 3 drives `alu_op` 010 (AND) when `opcode[0]`=0 and 011 (ADD) when it is 1. State 4 drives 001 (NOT B) when 0 and 100 (shift right B) when 1. Both states set `ac_ld`, perform the restore action and return to fetch.
- R5: Load-A sets `ar_sel`=1 and `ar_ld`=1. Load-B drives read and sets `dr_ld`. Load-C drives `alu_op`=000 (pass A), sets `ac_ld` and restores. The states run 8, 9, 10 and then fetch.
- R6: Store-A loads the address register from X. Store-B drives `mem_op`=10 (write) and `bus_drv`=1 and restores. Store-C drives nothing and returns to fetch.
- R7: Branch-A always restores. It goes to 12 when `ac_sign`=1 and to fetch otherwise. `ac_sign` has no effect in any other state.
- R8: Branch-B and jump set `pc_sel`=10, `pc_base`=1, `ar_sel`=1 and `ar_ld`=1, then go to fetch.
- R9: The restore action is `ar_sel`=0, `ar_ld`=1, `pc_sel`=10 (load base+2), `pc_base`=0. On every return to fetch, the address register equals the next instruction address and the program counter equals that address plus 2.
- R10: Every control output not named for a state is 0. `mem_op` is never 11, and `bus_drv` is high only together with a write.
- R11: A low `rst_n` in any state, including the middle of an instruction, puts the state at 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 5 | Opcode field of the latched instruction |
| ac_sign | input | 1 | Accumulator bit 15 |
| seq_state | output | 4 | Current state code |
| alu_op | output | 3 | ALU function |
| mem_op | output | 2 | Memory command: 00 idle, 01 read, 10 write |
| pc_sel | output | 2 | PC update: 00 hold, 01 clear, 10 load base+2 |
| pc_base | output | 1 | Adder base: 0 program counter, 1 X field |
| dr_ld | output | 1 | Load data register from the data bus |
| ac_ld | output | 1 | Load accumulator from the ALU |
| ar_sel | output | 1 | Address register source: 0 program counter, 1 X field |
| ar_ld | output | 1 | Load the address register |
| bus_drv | output | 1 | Accumulator drives the data bus |

## Verification
Two functions land in the same cycle. In several states the block both moves the address register and steps the program counter. The address register must take the old counter value while the counter takes base+2, and in branch-B and jump both take the X field. The bench sweeps all 32 opcodes against both sign values and a changing X field. It drives a small address model from the observed control outputs and judges at every return to fetch that the address register holds the expected instruction address and the counter is two beyond it.

// File: rtl/acs_pkg.sv
// Package: shared widths, state codes and control-word type for the
// accumulator control sequencer. Assumes a 4-bit state register.
package acs_pkg;
    localparam int ST_W   = 4;
    localparam int OPC_W  = 5;
    localparam int DEC_W  = 3;
    localparam int ALU_W  = 3;
    localparam int MEM_W  = 2;
    localparam int PCS_W  = 2;

    typedef enum logic [ST_W-1:0] {
        S_RST_A = 4'd0,  S_RST_B = 4'd1,  S_FETCH = 4'd2,  S_ALU2  = 4'd3,
        S_ALU1  = 4'd4,  S_STO_A = 4'd5,  S_STO_B = 4'd6,  S_STO_C = 4'd7,
        S_LD_A  = 4'd8,  S_LD_B  = 4'd9,  S_LD_C  = 4'd10, S_BR_A  = 4'd11,
        S_BR_B  = 4'd12, S_JUMP  = 4'd13
    } seq_state_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_PASSA = 3'd0, ALU_NOTB = 3'd1, ALU_AND = 3'd2,
        ALU_ADD   = 3'd3, ALU_SHRB = 3'd4
    } alu_op_e;

    typedef enum logic [MEM_W-1:0] {
        MEM_NOP = 2'd0, MEM_RD = 2'd1, MEM_WR = 2'd2
    } mem_op_e;

    typedef enum logic [PCS_W-1:0] {
        PC_HOLD = 2'd0, PC_CLEAR = 2'd1, PC_STEP = 2'd2
    } pc_sel_e;

    typedef struct packed {
        alu_op_e alu;
        mem_op_e mem;
        pc_sel_e pcs;
        logic    pc_base;
        logic    dr_ld;
        logic    ac_ld;
        logic    ar_sel;
        logic    ar_ld;
        logic    bus_drv;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{alu: ALU_PASSA, mem: MEM_NOP, pcs: PC_HOLD,
                                    pc_base: 1'b0, dr_ld: 1'b0, ac_ld: 1'b0,
                                    ar_sel: 1'b0, ar_ld: 1'b0, bus_drv: 1'b0};
endpackage

// File: rtl/acs_state_reg.sv
// State register of the sequencer. Synchronous active-low reset to reset-A.
// Assumes the next-state code is always defined.
module acs_state_reg
    import acs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] nxt,
    output logic [ST_W-1:0] state
);
    // Hold the current state; reset forces reset-A.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_RST_A;
        else        state <= nxt;
    end
endmodule

// File: rtl/acs_next_state.sv
// Next-state logic. Fetch decodes the low opcode bits. Branch-A checks the
// accumulator sign. Unused codes fall back to reset-A.
// Assumes the opcode is stable while fetch is active.
module acs_next_state
    import acs_pkg::*;
(
    input  logic [ST_W-1:0]  state,
    input  logic [DEC_W-1:0] opc_lo,
    input  logic             ac_sign,
    output logic [ST_W-1:0]  nxt
);
    // Pick the successor of the current state.
    always_comb begin
        nxt = S_RST_A;
        case (state)
            S_RST_A: nxt = S_RST_B;
            S_RST_B: nxt = S_FETCH;
            S_FETCH: begin
                case (opc_lo)
                    3'b000, 3'b001: nxt = S_ALU1;
                    3'b110, 3'b111: nxt = S_ALU2;
                    3'b010:         nxt = S_BR_A;
                    3'b011:         nxt = S_JUMP;
                    3'b100:         nxt = S_STO_A;
                    default:        nxt = S_LD_A;
                endcase
            end
            S_ALU2, S_ALU1: nxt = S_FETCH;
            S_STO_A: nxt = S_STO_B;
            S_STO_B: nxt = S_STO_C;
            S_STO_C: nxt = S_FETCH;
            S_LD_A:  nxt = S_LD_B;
            S_LD_B:  nxt = S_LD_C;
            S_LD_C:  nxt = S_FETCH;
            S_BR_A:  nxt = ac_sign ? S_BR_B : S_FETCH;
            S_BR_B, S_JUMP: nxt = S_FETCH;
            default: nxt = S_RST_A;
        endcase
    end
endmodule

// File: rtl/acs_ctrl_decode.sv
// Control-point decode. Each state maps to one control word. The ALU
// states also use the low opcode bit. Don't-care points are driven to 0.
module acs_ctrl_decode
    import acs_pkg::*;
(
    input  logic [ST_W-1:0] state,
    input  logic            opc_b0,
    output ctrl_t           ctl
);
    // Restore the fetch rule: address register <- PC, PC <- PC + 2.
    function automatic ctrl_t with_restore(input ctrl_t c);
        ctrl_t r = c;
        r.ar_sel  = 1'b0;
        r.ar_ld   = 1'b1;
        r.pcs     = PC_STEP;
        r.pc_base = 1'b0;
        return r;
    endfunction

    // Build the control word for the current state.
    always_comb begin
        ctl = CTRL_IDLE;
        case (state)
            S_RST_A: ctl.pcs = PC_CLEAR;
            S_RST_B: ctl = with_restore(CTRL_IDLE);
            S_FETCH: begin
                ctl.mem   = MEM_RD;
                ctl.dr_ld = 1'b1;
            end
            S_ALU2: begin
                ctl       = with_restore(CTRL_IDLE);
                ctl.alu   = opc_b0 ? ALU_ADD : ALU_AND;
                ctl.ac_ld = 1'b1;
            end
            S_ALU1: begin
                ctl       = with_restore(CTRL_IDLE);
                ctl.alu   = opc_b0 ? ALU_SHRB : ALU_NOTB;
                ctl.ac_ld = 1'b1;
            end
            S_STO_A, S_LD_A: begin
                ctl.ar_sel = 1'b1;
                ctl.ar_ld  = 1'b1;
            end
            S_STO_B: begin
                ctl         = with_restore(CTRL_IDLE);
                ctl.mem     = MEM_WR;
                ctl.bus_drv = 1'b1;
            end
            S_LD_B: begin
                ctl.mem   = MEM_RD;
                ctl.dr_ld = 1'b1;
            end
            S_LD_C: begin
                ctl       = with_restore(CTRL_IDLE);
                ctl.alu   = ALU_PASSA;
                ctl.ac_ld = 1'b1;
            end
            S_BR_A: ctl = with_restore(CTRL_IDLE);
            S_BR_B, S_JUMP: begin
                ctl.pcs     = PC_STEP;
                ctl.pc_base = 1'b1;
                ctl.ar_sel  = 1'b1;
                ctl.ar_ld   = 1'b1;
            end
            default: ctl = CTRL_IDLE;
        endcase
    end
endmodule

// File: rtl/acc_ctrl_seq.sv
// Top of the accumulator control sequencer: state register, next-state
// logic and control decode. Assumes direct addressing only; the upper
// opcode bits are not used for decode.
module acc_ctrl_seq
    import acs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             ac_sign,
    output logic [ST_W-1:0]  seq_state,
    output logic [ALU_W-1:0] alu_op,
    output logic [MEM_W-1:0] mem_op,
    output logic [PCS_W-1:0] pc_sel,
    output logic             pc_base,
    output logic             dr_ld,
    output logic             ac_ld,
    output logic             ar_sel,
    output logic             ar_ld,
    output logic             bus_drv
);
    logic [ST_W-1:0] state_q;
    logic [ST_W-1:0] state_d;
    ctrl_t           ctl;
    logic            opc_hi_unused;

    // Upper opcode bits carry no decode meaning in direct mode.
    assign opc_hi_unused = ^opcode[OPC_W-1:DEC_W];

    acs_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (state_d),
        .state (state_q)
    );

    acs_next_state u_nxt (
        .state   (state_q),
        .opc_lo  (opcode[DEC_W-1:0]),
        .ac_sign (ac_sign),
        .nxt     (state_d)
    );

    acs_ctrl_decode u_dec (
        .state  (state_q),
        .opc_b0 (opcode[0]),
        .ctl    (ctl)
    );

    // Drive the control points from the decoded word.
    always_comb begin
        seq_state = state_q;
        alu_op    = ctl.alu;
        mem_op    = ctl.mem;
        pc_sel    = ctl.pcs;
        pc_base   = ctl.pc_base;
        dr_ld     = ctl.dr_ld;
        ac_ld     = ctl.ac_ld;
        ar_sel    = ctl.ar_sel;
        ar_ld     = ctl.ar_ld;
        bus_drv   = ctl.bus_drv;
    end
endmodule

// File: rtl/acs_checker.sv
// Assertion checker for the sequencer, bound to the top module.
// Assumes synchronous active-low reset.
module acs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] state,
    input logic       ac_sign,
    input logic [1:0] mem_op,
    input logic       bus_drv,
    input logic       dr_ld
);
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state <= 4'd13);  // R1
    AST_RESETB_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'd1) |=> (state == 4'd2));  // R2
    AST_DR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dr_ld |-> (mem_op == 2'b01));  // R3
    AST_LOAD_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'd8) |=> (state == 4'd9));  // R5
    AST_STORE_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'd6) |=> (state == 4'd7));  // R6
    AST_BR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'd11 && ac_sign) |=> (state == 4'd12));  // R7
    AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'd11 && !ac_sign) |=> (state == 4'd2));  // R7
    AST_MEM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_op != 2'b11);  // R10
    AST_BUS_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drv |-> (mem_op == 2'b10));  // R10
endmodule

bind acc_ctrl_seq acs_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state_q),
    .ac_sign (ac_sign),
    .mem_op  (mem_op),
    .bus_drv (bus_drv),
    .dr_ld   (dr_ld)
);

// File: tb/acc_ctrl_seq_test.sv
// Sweep bench: every opcode with both sign values, per-cycle control checks,
// and an address model that checks the fetch rule.
module acc_ctrl_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] opcode = '0;
    logic       ac_sign = 1'b0;
    logic [3:0] seq_state;
    logic [2:0] alu_op;
    logic [1:0] mem_op, pc_sel;
    logic       pc_base, dr_ld, ac_ld, ar_sel, ar_ld, bus_drv;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [3:0]  exp_state;
    logic [15:0] pc_m = '0, ar_m = '0, exp_addr = '0;
    logic [9:0]  xfld = '0;

    always #4 clk = ~clk;  // 125 MHz

    acc_ctrl_seq uut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .ac_sign(ac_sign),
        .seq_state(seq_state), .alu_op(alu_op), .mem_op(mem_op),
        .pc_sel(pc_sel), .pc_base(pc_base), .dr_ld(dr_ld), .ac_ld(ac_ld),
        .ar_sel(ar_sel), .ar_ld(ar_ld), .bus_drv(bus_drv)
    );

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h state=%0d op=%b", req, act, exp, seq_state, opcode);
        end
    endtask

    // Expected control word {alu,mem,pcsel,base,dr,ac,arsel,arld,bus} per R2-R9.
    function automatic logic [12:0] exp_out(input logic [3:0] st, input logic b0);
        logic [2:0] a = 0; logic [1:0] m = 0, ps = 0;
        logic pb = 0, dl = 0, al = 0, asl = 0, ald = 0, bd = 0;
        bit rst = 0;
        case (st)
            4'd0: ps = 2'b01;
            4'd1: rst = 1;
            4'd2: begin m = 2'b01; dl = 1; end
            4'd3: begin rst = 1; a = b0 ? 3'b011 : 3'b010; al = 1; end
            4'd4: begin rst = 1; a = b0 ? 3'b100 : 3'b001; al = 1; end
            4'd5, 4'd8: begin asl = 1; ald = 1; end
            4'd6: begin rst = 1; m = 2'b10; bd = 1; end
            4'd9: begin m = 2'b01; dl = 1; end
            4'd10: begin rst = 1; al = 1; end
            4'd11: rst = 1;
            4'd12, 4'd13: begin ps = 2'b10; pb = 1; asl = 1; ald = 1; end
            default: ;
        endcase
        if (rst) begin ps = 2'b10; pb = 0; asl = 0; ald = 1; end
        return {a, m, ps, pb, dl, al, asl, ald, bd};
    endfunction

    function automatic string tag_of(input logic [3:0] st);
        case (st)
            4'd0, 4'd1: return "R2";
            4'd2: return "R3";
            4'd3, 4'd4: return "R4";
            4'd5, 4'd6, 4'd7: return "R6";
            4'd8, 4'd9, 4'd10: return "R5";
            4'd11: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [3:0] exp_next(input logic [3:0] st, input logic [4:0] op, input logic sg);
        case (st)
            4'd0: return 4'd1;
            4'd1: return 4'd2;
            4'd2: case (op[2:0])
                      3'b000, 3'b001: return 4'd4;
                      3'b110, 3'b111: return 4'd3;
                      3'b010: return 4'd11;
                      3'b011: return 4'd13;
                      3'b100: return 4'd5;
                      default: return 4'd8;
                  endcase
            4'd5: return 4'd6;
            4'd6: return 4'd7;
            4'd8: return 4'd9;
            4'd9: return 4'd10;
            4'd11: return sg ? 4'd12 : 4'd2;
            default: return 4'd2;
        endcase
    endfunction

    // Check the present cycle at the falling edge, advance the model, wait one cycle.
    task automatic step();
        logic [12:0] got, exp;
        logic [15:0] base;
        logic [3:0] nxt;
        got = {alu_op, mem_op, pc_sel, pc_base, dr_ld, ac_ld, ar_sel, ar_ld, bus_drv};
        exp = exp_out(exp_state, opcode[0]);
        check(seq_state == exp_state, "R1", 16'(seq_state), 16'(exp_state));
        check(got == exp, tag_of(exp_state), 16'(got), 16'(exp));
        check(!(mem_op == 2'b11) && !(bus_drv && mem_op != 2'b10), "R10", 16'(mem_op), 16'd0);
        base = pc_base ? 16'(xfld) : pc_m;
        if (ar_ld) ar_m = ar_sel ? 16'(xfld) : pc_m;
        if (pc_sel == 2'b01) pc_m = '0;
        else if (pc_sel == 2'b10) pc_m = base + 16'd2;
        nxt = exp_next(exp_state, opcode, ac_sign);
        @(negedge clk);
        exp_state = nxt;
    endtask

    task automatic run_instr(input logic [4:0] op, input logic sg, input logic [9:0] x);
        int n = 0;
        opcode = op; ac_sign = sg; xfld = x;
        if ((op[2:0] == 3'b010 && sg) || op[2:0] == 3'b011) exp_addr = 16'(x);
        else exp_addr = exp_addr + 16'd2;
        step();
        while (exp_state != 4'd2 && n < 8) begin step(); n++; end
        // R9: fetch rule holds on return
        check(ar_m == exp_addr, "R9", ar_m, exp_addr);
        check(pc_m == exp_addr + 16'd2, "R9", pc_m, exp_addr + 16'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset held low parks the state at 0, reset-A outputs (R2)
        check(seq_state == 4'd0, "R1", 16'(seq_state), 16'd0);
        check({alu_op, mem_op, pc_sel, pc_base, dr_ld, ac_ld, ar_sel, ar_ld, bus_drv} == exp_out(4'd0, 1'b0),
              "R2", 16'(pc_sel), 16'd1);
        rst_n = 1'b1;
        exp_state = 4'd0;
        step(); step();
        exp_addr = '0;
        check(ar_m == 16'd0 && pc_m == 16'd2, "R9", pc_m, 16'd2);
        for (int op = 0; op < 32; op++) begin
            for (int sg = 0; sg < 2; sg++) begin
                run_instr(5'(op), 1'(sg), 10'(((op * 2 + sg) * 14 + 100) & 10'h3FE));
            end
        end
        // R11: reset in the middle of a load
        opcode = 5'b00101; ac_sign = 1'b0;
        step(); step();
        check(seq_state == 4'd9, "R11", 16'(seq_state), 16'd9);
        rst_n = 1'b0;
        @(negedge clk);
        check(seq_state == 4'd0, "R11", 16'(seq_state), 16'd0);
        check(pc_sel == 2'b01 && ar_ld == 1'b0 && mem_op == 2'b00, "R11", 16'(pc_sel), 16'd1);
        rst_n = 1'b1;
        exp_state = 4'd0;
        step(); step();
        exp_addr = '0;
        // R3: upper opcode bits ignored after restart
        run_instr(5'b11110, 1'b1, 10'd300);
        run_instr(5'b10011, 1'b0, 10'd512);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule